// File: doc/BRIEF.md
# TLB Bulk Invalidation Scanner

This block removes translations from a TLB in bulk. The TLB has two regions. The set-associative region is organised as `WAYS` ways of `LINES` lines each. The fully associative region holds `FA_N` entries. Entries are numbered way-major: entry `w*LINES + l` is line `l` of way `w`, and the fully associative entries follow at `WAYS*LINES` and above.

A single start pulse loads a command together with its operands: an index, an address-space identifier, a global-bit value, a virtual address and the page size used by the set-associative region. The engine then walks the selected entries through an external storage port, one entry per cycle. The storage returns the entry's exists bit, global bit, ASID, virtual page-pair number and page size in the same cycle. The engine raises a clear strobe for every entry that must be dropped.

When the walk ends, the engine gives a one-cycle completion pulse. In the same cycle it gives a flush pulse for any downstream translation cache. Lookup and refill are outside this block.

Top module: `tlbinv_engine`

## Requirements
- R1: A `start` seen while idle loads all command fields. The command codes are: 0 clear-line, 1 flush-line, 2 drop-all, 3 drop-by-global-value, 4 drop-by-ASID, 5 page drop for private entries, 6 page drop for shared-or-own entries, 7 no-op.
- R2: Invalidation only ever clears the exists bit. `ent_clr` is asserted only in a cycle where `ent_rd` is high, the addressed entry exists and it matches the command. Each cycle addresses at most one entry, and the address always stays below `WAYS*LINES+FA_N`.
- R3: For clear-line with an index below `WAYS*LINES`, the engine visits line `index mod LINES` in every way, at address `w*LINES + index mod LINES`. It clears only entries whose global bit is 0 and whose ASID equals the command ASID.
- R4: For a line command whose index lies in `[WAYS*LINES, WAYS*LINES+FA_N)`, the engine applies the same line rule to every fully associative entry instead.
- R5: Flush-line selects entries exactly as R3/R4 do. It clears every existing entry it visits, whatever its ASID or global bit.
- R6: A line command with an index at or above `WAYS*LINES+FA_N`, and command 7, clear nothing. They still produce the completion and flush pulses.
- R7: Drop-all clears every entry. Drop-by-global-value clears entries whose global bit equals `cmd_global`. Drop-by-ASID clears entries that are not global and whose ASID equals `cmd_asid`.
- R8: A page match holds when `vaddr >> (ps+1)` equals `(vppn << 13) >> (ps+1)`. Here `ps` is `sa_ps` for set-associative entries and the entry's own page size for fully associative entries.
- R9: Command 5 clears page-matching entries that are not global and have an equal ASID. Command 6 clears page-matching entries that are global or have an equal ASID.
- R10: `done` and `flush_req` are high together for exactly one cycle. This happens N+1 cycles after the start edge, where N is the number of entries visited: `WAYS` for a set-associative line, `FA_N` for the associative region, all entries for commands 2–6, and 0 otherwise. `busy` is high from the cycle after start through the `done` cycle.
- R11: A `start` while `busy` is high is ignored. It does not change the running command, and it does not produce a second completion.
- R12: After reset, `busy`, `done`, `flush_req`, `ent_rd` and `ent_clr` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a command (ignored while busy) |
| cmd_op | input | 3 | Command code |
| cmd_index | input | IDX_W | Entry index for line commands |
| cmd_asid | input | 10 | Address-space identifier operand |
| cmd_global | input | 1 | Global-bit value for command 3 |
| cmd_vaddr | input | 48 | Virtual address for page commands |
| sa_ps | input | 6 | Page size of set-associative entries |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| flush_req | output | 1 | Downstream translation-cache flush pulse |
| ent_addr | output | ADDR_W | Entry being visited |
| ent_rd | output | 1 | `ent_addr` is valid this cycle |
| ent_exists | input | 1 | Exists bit of visited entry |
| ent_global | input | 1 | Global bit of visited entry |
| ent_asid | input | 10 | ASID of visited entry |
| ent_vppn | input | 35 | Virtual page-pair number (address bits 47:13) |
| ent_ps | input | 6 | Page size stored in the visited entry |
| ent_clr | output | 1 | Clear the exists bit of `ent_addr` at this edge |

## Verification
The hardest condition to reach is a `start` that arrives in the middle of a walk. In that case the loaded command must survive, and no extra completion may follow. The bench times a drop-all request one cycle into a short line walk. It then confirms that only the line walk's clears occurred and that `done` stays low afterwards.

Page matching is another difficult area. It mixes the shared page size with per-entry sizes, so the bench seeds fully associative entries with three different sizes. It chooses virtual addresses that match some entries at one size and miss them at another.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    localparam int ASID_W   = 10;
    localparam int VA_W     = 48;
    localparam int PAGE_LSB = 13;
    localparam int VPPN_W   = VA_W - PAGE_LSB;
    localparam int PS_W     = 6;

    typedef enum logic [2:0] {
        OP_CLR_LINE    = 3'd0,
        OP_FLUSH_LINE  = 3'd1,
        OP_INV_ALL     = 3'd2,
        OP_INV_GVAL    = 3'd3,
        OP_INV_ASID    = 3'd4,
        OP_PAGE_PRIV   = 3'd5,
        OP_PAGE_SHARED = 3'd6,
        OP_NOP         = 3'd7
    } inv_op_e;

    typedef struct packed {
        inv_op_e             op;
        logic [ASID_W-1:0]   asid;
        logic                gval;
        logic [VA_W-1:0]     va;
        logic [PS_W-1:0]     sa_ps;
    } inv_req_t;

    function automatic logic is_line_op(inv_op_e op);
        return (op == OP_CLR_LINE) || (op == OP_FLUSH_LINE);
    endfunction

    // Bits at or above ps+1 take part in a page-pair comparison.
    function automatic logic [VA_W-1:0] pair_mask(logic [PS_W-1:0] ps);
        logic [PS_W:0] sh;
        sh = {1'b0, ps} + {{PS_W{1'b0}}, 1'b1};
        return {VA_W{1'b1}} << sh;
    endfunction

endpackage

// File: rtl/tlbinv_range.sv
module tlbinv_range
    import tlbinv_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int LINES  = 256,
    parameter int FA_N   = 64,
    parameter int IDX_W  = 12,
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 12
) (
    input  inv_op_e           op,
    input  logic [IDX_W-1:0]  index,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] stride,
    output logic [CNT_W-1:0]  count
);
    localparam int SA_N  = WAYS * LINES;
    localparam int TOTAL = SA_N + FA_N;

    logic [31:0] idx32;
    assign idx32 = 32'(index);

    always_comb begin
        base   = '0;
        stride = ADDR_W'(1);
        count  = '0;
        if (is_line_op(op)) begin
            if (idx32 < 32'(SA_N)) begin
                base   = ADDR_W'(idx32 % 32'(LINES));
                stride = ADDR_W'(LINES);
                count  = CNT_W'(WAYS);
            end else if (idx32 < 32'(TOTAL)) begin
                base   = ADDR_W'(SA_N);
                count  = CNT_W'(FA_N);
            end
        end else if (op != OP_NOP) begin
            count = CNT_W'(TOTAL);
        end
    end
endmodule

// File: rtl/tlbinv_seq.sv
module tlbinv_seq #(
    parameter int ADDR_W = 12,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [CNT_W-1:0]  count,
    output logic              busy,
    output logic              acc_valid,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              fin
);
    typedef enum logic [1:0] {S_IDLE, S_SCAN, S_FIN} st_e;

    st_e               state;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] stride_q;
    logic [CNT_W-1:0]  remain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            addr_q   <= '0;
            stride_q <= '0;
            remain_q <= '0;
        end else begin
            case (state)
                S_IDLE: if (launch) begin
                    addr_q   <= base;
                    stride_q <= stride;
                    remain_q <= count;
                    state    <= (count == '0) ? S_FIN : S_SCAN;
                end
                S_SCAN: begin
                    addr_q   <= addr_q + stride_q;
                    remain_q <= remain_q - CNT_W'(1);
                    if (remain_q == CNT_W'(1)) state <= S_FIN;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign acc_valid = (state == S_SCAN);
    assign acc_addr  = addr_q;
    assign fin       = (state == S_FIN);

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin); // R10
    AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (rst)
        launch |=> busy); // R10
    AST_SCAN_LEADS_FIN: assert property (@(posedge clk) disable iff (rst)
        fin |-> $past(busy) || $past(launch)); // R10
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int SA_N   = 2048
) (
    input  inv_req_t          req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              ent_global,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPPN_W-1:0] ent_vppn,
    input  logic [PS_W-1:0]   ent_ps,
    output logic              hit
);
    logic [PS_W-1:0] ps_sel;
    logic [VA_W-1:0] ent_va;
    logic            asid_eq;
    logic            page_eq;

    assign ps_sel  = (32'(acc_addr) >= 32'(SA_N)) ? ent_ps : req.sa_ps;
    assign ent_va  = {ent_vppn, {PAGE_LSB{1'b0}}};
    assign asid_eq = (ent_asid == req.asid);
    assign page_eq = ((req.va ^ ent_va) & pair_mask(ps_sel)) == '0;

    always_comb begin
        unique case (req.op)
            OP_CLR_LINE:    hit = !ent_global && asid_eq;
            OP_FLUSH_LINE:  hit = 1'b1;
            OP_INV_ALL:     hit = 1'b1;
            OP_INV_GVAL:    hit = (ent_global == req.gval);
            OP_INV_ASID:    hit = !ent_global && asid_eq;
            OP_PAGE_PRIV:   hit = !ent_global && asid_eq && page_eq;
            OP_PAGE_SHARED: hit = (ent_global || asid_eq) && page_eq;
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_engine.sv
module tlbinv_engine
    import tlbinv_pkg::*;
#(
    parameter int WAYS   = 8,
    parameter int LINES  = 256,
    parameter int FA_N   = 64,
    parameter int IDX_W  = 12,
    localparam int SA_N   = WAYS * LINES,
    localparam int TOTAL  = SA_N + FA_N,
    localparam int ADDR_W = $clog2(TOTAL),
    localparam int CNT_W  = $clog2(TOTAL + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [ASID_W-1:0] cmd_asid,
    input  logic              cmd_global,
    input  logic [VA_W-1:0]   cmd_vaddr,
    input  logic [PS_W-1:0]   sa_ps,
    output logic              busy,
    output logic              done,
    output logic              flush_req,
    output logic [ADDR_W-1:0] ent_addr,
    output logic              ent_rd,
    input  logic              ent_exists,
    input  logic              ent_global,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPPN_W-1:0] ent_vppn,
    input  logic [PS_W-1:0]   ent_ps,
    output logic              ent_clr
);
    inv_req_t          req_q;
    inv_op_e           op_in;
    logic              launch;
    logic              fin;
    logic              hit;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] stride;
    logic [CNT_W-1:0]  count;

    assign op_in  = inv_op_e'(cmd_op);
    assign launch = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{op: OP_NOP, default: '0};
        end else if (launch) begin
            req_q <= '{op: op_in, asid: cmd_asid, gval: cmd_global,
                       va: cmd_vaddr, sa_ps: sa_ps};
        end
    end

    tlbinv_range #(
        .WAYS(WAYS), .LINES(LINES), .FA_N(FA_N),
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_range (
        .op(op_in), .index(cmd_index),
        .base(base), .stride(stride), .count(count)
    );

    tlbinv_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst(rst), .launch(launch),
        .base(base), .stride(stride), .count(count),
        .busy(busy), .acc_valid(ent_rd), .acc_addr(ent_addr), .fin(fin)
    );

    tlbinv_match #(.ADDR_W(ADDR_W), .SA_N(SA_N)) u_match (
        .req(req_q), .acc_addr(ent_addr),
        .ent_global(ent_global), .ent_asid(ent_asid),
        .ent_vppn(ent_vppn), .ent_ps(ent_ps), .hit(hit)
    );

    assign ent_clr   = ent_rd && ent_exists && hit;
    assign done      = fin;
    assign flush_req = fin;

    AST_CLR_NEEDS_ENTRY: assert property (@(posedge clk) disable iff (rst)
        ent_clr |-> ent_rd && ent_exists); // R2
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        ent_rd |-> (32'(ent_addr) < 32'(TOTAL))); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy || $stable(req_q)); // R11
    AST_FLUSH_AFTER_WORK: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> $past(busy) || $past(start)); // R10
endmodule

// File: tb/tb_tlbinv_engine.sv
module tb_tlbinv_engine;
    localparam int WAYS = 4, LINES = 8, FA_N = 4, IDX_W = 7;
    localparam int SA_N = WAYS * LINES;
    localparam int TOTAL = SA_N + FA_N;
    localparam int ADDR_W = $clog2(TOTAL);

    logic clk = 0, rst = 1, start = 0;
    logic [2:0] cmd_op = 0;
    logic [IDX_W-1:0] cmd_index = 0;
    logic [9:0] cmd_asid = 0;
    logic cmd_global = 0;
    logic [47:0] cmd_vaddr = 0;
    logic [5:0] sa_ps = 13;
    logic busy, done, flush_req, ent_rd, ent_clr;
    logic [ADDR_W-1:0] ent_addr;
    logic ent_exists, ent_global;
    logic [9:0] ent_asid;
    logic [34:0] ent_vppn;
    logic [5:0] ent_ps;

    logic m_ex [TOTAL];
    logic m_g [TOTAL];
    logic [9:0] m_asid [TOTAL];
    logic [34:0] m_vppn [TOTAL];
    logic [5:0] m_ps [TOTAL];
    logic s_ex [TOTAL];

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    tlbinv_engine #(.WAYS(WAYS), .LINES(LINES), .FA_N(FA_N), .IDX_W(IDX_W)) dut (
        .clk(clk), .rst(rst), .start(start), .cmd_op(cmd_op), .cmd_index(cmd_index),
        .cmd_asid(cmd_asid), .cmd_global(cmd_global), .cmd_vaddr(cmd_vaddr),
        .sa_ps(sa_ps), .busy(busy), .done(done), .flush_req(flush_req),
        .ent_addr(ent_addr), .ent_rd(ent_rd), .ent_exists(ent_exists),
        .ent_global(ent_global), .ent_asid(ent_asid), .ent_vppn(ent_vppn),
        .ent_ps(ent_ps), .ent_clr(ent_clr)
    );

    wire in_rng = (int'(ent_addr) < TOTAL);
    assign ent_exists = in_rng ? m_ex[ent_addr] : 1'b0;
    assign ent_global = in_rng ? m_g[ent_addr] : 1'b0;
    assign ent_asid   = in_rng ? m_asid[ent_addr] : '0;
    assign ent_vppn   = in_rng ? m_vppn[ent_addr] : '0;
    assign ent_ps     = in_rng ? m_ps[ent_addr] : '0;

    always @(posedge clk) if (ent_clr && in_rng) m_ex[ent_addr] <= 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic fill(input int seed);
        for (int i = 0; i < TOTAL; i++) begin
            int h;
            h = (seed * 1103 + i * 2671 + (i * i) * 37) ^ (seed << 3);
            if (h < 0) h = -h;
            m_ex[i]   = (h % 7) != 0;
            m_g[i]    = ((h >> 2) % 3) == 0;
            m_asid[i] = 10'(5 + ((h >> 4) % 2));
            case ((h >> 6) % 4)
                0: m_vppn[i] = 35'h10;
                1: m_vppn[i] = 35'h11;
                2: m_vppn[i] = 35'h12;
                default: m_vppn[i] = 35'h100;
            endcase
            case ((h >> 8) % 3)
                0: m_ps[i] = 6'd13;
                1: m_ps[i] = 6'd14;
                default: m_ps[i] = 6'd21;
            endcase
        end
    endtask

    function automatic bit want_clear(int op, int idx, int asid, bit gv,
                                      longint unsigned va, int sps, int i);
        bit aeq, pg, sel;
        int ps;
        longint unsigned ev;
        aeq = (int'(m_asid[i]) == asid);
        ps  = (i < SA_N) ? sps : int'(m_ps[i]);
        ev  = longint'(m_vppn[i]) << 13;
        pg  = ((va >> (ps + 1)) == (ev >> (ps + 1)));
        if (idx < SA_N) sel = (i < SA_N) && ((i % LINES) == (idx % LINES));
        else if (idx < TOTAL) sel = (i >= SA_N);
        else sel = 0;
        case (op)
            0: return sel && !m_g[i] && aeq;          // R3 R4
            1: return sel;                           // R5
            2: return 1;                             // R7
            3: return m_g[i] == gv;                  // R7
            4: return !m_g[i] && aeq;                // R7
            5: return !m_g[i] && aeq && pg;          // R8 R9
            6: return (m_g[i] || aeq) && pg;         // R8 R9
            default: return 0;                       // R6
        endcase
    endfunction

    function automatic int visits(int op, int idx);
        if (op <= 1) return (idx < SA_N) ? WAYS : (idx < TOTAL) ? FA_N : 0;
        if (op <= 6) return TOTAL;
        return 0;
    endfunction

    task automatic run(input int op, input int idx, input int asid, input bit gv,
                       input longint unsigned va, input int sps, input string tag);
        int cyc, bad, first;
        bit exp_ex [TOTAL];
        for (int i = 0; i < TOTAL; i++) begin
            s_ex[i] = m_ex[i];
            exp_ex[i] = m_ex[i] && !want_clear(op, idx, asid, gv, va, sps, i);
        end
        cmd_op = 3'(op); cmd_index = IDX_W'(idx); cmd_asid = 10'(asid);
        cmd_global = gv; cmd_vaddr = 48'(va); sa_ps = 6'(sps); start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 200) begin @(negedge clk); cyc++; end
        chk(cyc == visits(op, idx) + 1, {tag, " R10 latency"}, cyc, visits(op, idx) + 1);
        chk(flush_req === 1'b1, {tag, " R10 flush with done"}, flush_req, 1);
        bad = 0; first = -1;
        for (int i = 0; i < TOTAL; i++)
            if (m_ex[i] !== exp_ex[i]) begin bad++; if (first < 0) first = i; end
        if (first < 0) first = 0;
        chk(bad == 0, {tag, " R2 exists bits"}, m_ex[first], exp_ex[first]);
        @(negedge clk);
        chk(!done && !flush_req && !busy, {tag, " R10 single pulse"}, done, 0);
    endtask

    initial begin
        #(20 * 150000);
        chk(0, "watchdog", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        fill(1);
        repeat (3) @(negedge clk);
        rst = 0;
        chk(!busy && !done && !flush_req && !ent_rd && !ent_clr, "R12 reset idle", busy, 0);
        @(negedge clk);

        seed = 2;
        // R3 R4 R5 R6: line commands over every index region and past the end
        for (int op = 0; op <= 1; op++)
            for (int idx = 0; idx < TOTAL + 6; idx++) begin
                fill(seed++);
                run(op, idx, 5 + (idx % 2), 0, 0, 13, op == 0 ? "R3/R4 clear-line" : "R5 flush-line");
            end
        fill(seed++); run(0, 100, 5, 0, 0, 13, "R6 far index");

        // R7: whole-array commands
        for (int gv = 0; gv <= 1; gv++)
            for (int a = 5; a <= 6; a++) begin
                fill(seed++); run(2, 0, a, 1'(gv), 0, 13, "R7 all");
                fill(seed++); run(3, 0, a, 1'(gv), 0, 13, "R7 by-global");
                fill(seed++); run(4, 0, a, 1'(gv), 0, 13, "R7 by-asid");
                fill(seed++); run(7, 3, a, 1'(gv), 0, 13, "R6 no-op");
            end

        // R8 R9: page commands with both shared sizes and several addresses
        for (int op = 5; op <= 6; op++)
            for (int sps = 13; sps <= 14; sps++)
                for (int a = 5; a <= 6; a++)
                    for (int k = 0; k < 4; k++) begin
                        longint unsigned va;
                        case (k)
                            0: va = (64'h11 << 13) | 64'h5a;
                            1: va = (64'h10 << 13) | 64'h1fff;
                            2: va = 64'h100 << 13;
                            default: va = 64'h12 << 13;
                        endcase
                        fill(seed++);
                        run(op, 0, a, 0, va, sps, op == 5 ? "R9 page private" : "R9 page shared");
                    end

        // R11: start during a walk is ignored
        begin
            bit exp_ex [TOTAL];
            int bad, extra;
            fill(77);
            for (int i = 0; i < TOTAL; i++)
                exp_ex[i] = m_ex[i] && !want_clear(0, 3, 5, 0, 0, 13, i);
            cmd_op = 3'd0; cmd_index = 7'd3; cmd_asid = 10'd5; start = 1;
            @(negedge clk);
            cmd_op = 3'd2; cmd_asid = 10'd6;
            @(negedge clk);
            start = 0;
            while (!done) @(negedge clk);
            extra = 0;
            repeat (40) begin @(negedge clk); if (done) extra++; end
            bad = 0;
            for (int i = 0; i < TOTAL; i++) if (m_ex[i] !== exp_ex[i]) bad++;
            chk(bad == 0, "R11 busy start kept running command", bad, 0);
            chk(extra == 0, "R11 no second completion", extra, 0);
        end

        // R1: code 4 vs code 7 loaded from the same operands
        fill(91); run(4, 0, 6, 0, 0, 13, "R1 code 4");
        fill(91); run(7, 0, 6, 0, 0, 13, "R1 code 7");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule